// File: doc/BRIEF.md
# Main Clock Loss Detector

This block watches the main system clock from a separate, always-running reference clock. That reference clock stands in for an on-chip ring oscillator. The main clock drives a small divider. The divider's top bit crosses into the reference domain, and the block counts its transitions over fixed windows of reference cycles. A window that sees fewer than `MIN_TOG` transitions is a failing verdict. The first failing verdict raises a reset request, and the request is held while the main clock stays slow. The request and everything that decides it are registered on the reference clock, so the block can keep reset asserted while the main clock is dead. The pass threshold in main-clock frequency is `MIN_TOG * f_ref * 2^(DIV_BITS-1) / WIN_LEN`, and the parameters are chosen to place it near 20 kHz on the target.

Software arms the detector by writing an enable bit. A power-fail reset also clears that bit. A latched failure flag records that a trip happened. Software clears the flag, and a power-on reset clears it as well. When the system deliberately enters stop mode, the detector is suppressed, because a stopped clock is then expected.

The control is one state machine with four states:
- **IDLE**: detector off, no request.
- **RUN**: watching, no request.
- **TRIP**: the main clock has failed; request asserted.
- **HEAL**: one passing window has been seen after a failure; request still asserted.

The transitions are:
- **ARM**: IDLE to RUN, once enabled and not in stop mode.
- **TRIP**: RUN to TRIP on a failing verdict.
- **HOLD**: TRIP stays in TRIP on a failing verdict.
- **MEND**: TRIP to HEAL on a passing verdict.
- **RELAPSE**: HEAL back to TRIP on a failing verdict.
- **CLEAR**: HEAL to RUN on a passing verdict.
- **SUSPEND**: any state to IDLE when the enable is 0 or the synchronized stop indication is 1.

Top module: `clk_loss_guard`

## Requirements
- R1: After `por_rst`, both `rst_req` and `fail_flag` read 0. While the enable bit is 0, `rst_req` stays 0 whatever the main clock does.
- R2: When a window ends with fewer than `MIN_TOG` divided-clock transitions while in RUN, `rst_req` and `fail_flag` both become 1 at the same reference edge.
- R3: Between window ends, `rst_req` keeps its value while the detector stays enabled and out of stop mode. A failing verdict in TRIP keeps it at 1.
- R4: Releasing the request takes two passing windows in a row (TRIP to HEAL to RUN). A failing window in HEAL goes back to TRIP with the request still 1.
- R5: A main clock whose transitions per window reach `MIN_TOG` never raises `rst_req`.
- R6: Writing 0 to the enable bit (`sw_en_we`=1, `sw_en_wd`=0 at edge k) drives `rst_req` to 0 at edge k+1.
- R7: `stop_req` passes through two reference-clock flops. A 1 sampled at edge k forces IDLE, and `rst_req` becomes 0 at edge k+2. No request is raised while stop mode lasts, and `fail_flag` keeps its value.
- R8: `pfail_rst` clears the enable bit asynchronously, so `rst_req` is 0 after the next reference edge. `fail_flag` is not changed by `pfail_rst`.
- R9: `sw_flag_clr` at an edge clears `fail_flag`. `por_rst` clears `fail_flag` but leaves the enable bit set, so the detector re-arms after reset.
- R10: If a failing verdict and `sw_flag_clr` fall on the same edge, `fail_flag` is 1 afterwards; setting wins.
- R11: The first verdict after ARM is made exactly `WIN_LEN` reference cycles after the ARM edge. With an enable write at edge k and a slow main clock, `rst_req` is 0 after edge k+`WIN_LEN` and 1 after edge k+1+`WIN_LEN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock; all decisions are made here |
| main_clk | input | 1 | Monitored main clock |
| por_rst | input | 1 | Power-on reset, active high, asynchronous; clears state and flag |
| pfail_rst | input | 1 | Power-fail reset, active high, asynchronous; clears the enable bit |
| sw_en_we | input | 1 | Software write strobe for the enable bit (reference domain) |
| sw_en_wd | input | 1 | Value written to the enable bit |
| sw_flag_clr | input | 1 | Software clear strobe for the failure flag (reference domain) |
| stop_req | input | 1 | Deliberate stop-mode indication, asynchronous |
| rst_req | output | 1 | Reset request, registered on `ref_clk` |
| fail_flag | output | 1 | Latched failure flag |

## Verification
A failing window verdict sets the flag in the same cycle as a software clear can try to drop it. The bench arranges this by waiting until its model reports the last cycle of a window whose main clock is slow, then pulsing `sw_flag_clr` so that it is sampled at the verdict edge. The flag must read 1 afterwards and the request must be raised. A second overlap is the loss of enable or the start of stop mode while the request is held. For these, the bench checks that suppression beats the verdict and that the request drops with the latency stated in R6, R7 and R8.

// File: rtl/clg_pkg.sv
package clg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_TRIP = 2'd2,
        ST_HEAL = 2'd3
    } guard_state_t;
endpackage

// File: rtl/clg_sync.sv
// Multi-flop synchronizer into the reference domain, asynchronous reset to 0.
module clg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or posedge arst) begin
                if (arst) chain[0] <= 1'b0;
                else      chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or posedge arst) begin
                if (arst) chain[i] <= 1'b0;
                else      chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clg_tick.sv
// Divider in the main clock domain; its top bit is the signal sent across.
module clg_tick #(
    parameter int DIV_BITS = 1
) (
    input  logic main_clk,
    input  logic arst,
    output logic tog
);
    logic [DIV_BITS-1:0] div_q;

    always_ff @(posedge main_clk or posedge arst) begin
        if (arst) div_q <= '0;
        else      div_q <= div_q + DIV_BITS'(1);
    end

    assign tog = div_q[DIV_BITS-1];
endmodule

// File: rtl/clg_window.sv
// Window timer and saturating transition counter in the reference domain.
module clg_window #(
    parameter int WIN_LEN = 256,
    parameter int MIN_TOG = 8
) (
    input  logic clk,
    input  logic arst,
    input  logic run,
    input  logic tick,
    output logic win_end,
    output logic win_pass
);
    localparam int WCW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam int CW  = $clog2(MIN_TOG + 1);
    localparam logic [WCW-1:0] WC_LAST = WCW'(WIN_LEN - 1);
    localparam logic [CW-1:0]  CNT_SAT = CW'(MIN_TOG);

    logic [WCW-1:0] wc_q;
    logic [CW-1:0]  cnt_q;
    logic [CW:0]    cnt_sum;

    assign win_end  = run && (wc_q == WC_LAST);
    assign cnt_sum  = {1'b0, cnt_q} + {{CW{1'b0}}, tick};
    assign win_pass = (cnt_sum >= {1'b0, CNT_SAT});

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            wc_q  <= '0;
            cnt_q <= '0;
        end else if (!run || win_end) begin
            wc_q  <= '0;
            cnt_q <= '0;
        end else begin
            wc_q  <= wc_q + WCW'(1);
            if (cnt_q != CNT_SAT) cnt_q <= cnt_q + CW'(tick);
        end
    end
endmodule

// File: rtl/clk_loss_guard.sv
module clk_loss_guard
    import clg_pkg::*;
#(
    parameter int WIN_LEN     = 256,
    parameter int MIN_TOG     = 8,
    parameter int DIV_BITS    = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic main_clk,
    input  logic por_rst,
    input  logic pfail_rst,
    input  logic sw_en_we,
    input  logic sw_en_wd,
    input  logic sw_flag_clr,
    input  logic stop_req,
    output logic rst_req,
    output logic fail_flag
);
    logic tog_main, tog_s, tog_d, tick;
    logic stop_s, en_q, run;
    logic win_end, win_pass, trip_now;
    guard_state_t state_q, state_d;

    // Main-domain divider and its crossing
    clg_tick #(.DIV_BITS(DIV_BITS)) u_tick (
        .main_clk (main_clk),
        .arst     (por_rst),
        .tog      (tog_main)
    );

    clg_sync #(.STAGES(SYNC_STAGES)) u_tog_sync (
        .clk  (ref_clk),
        .arst (por_rst),
        .d    (tog_main),
        .q    (tog_s)
    );

    clg_sync #(.STAGES(SYNC_STAGES)) u_stop_sync (
        .clk  (ref_clk),
        .arst (por_rst),
        .d    (stop_req),
        .q    (stop_s)
    );

    always_ff @(posedge ref_clk or posedge por_rst) begin
        if (por_rst) tog_d <= 1'b0;
        else         tog_d <= tog_s;
    end

    assign tick = tog_s ^ tog_d;

    // Enable bit: software write, cleared only by power-fail
    always_ff @(posedge ref_clk or posedge pfail_rst) begin
        if (pfail_rst)     en_q <= 1'b0;
        else if (sw_en_we) en_q <= sw_en_wd;
    end

    assign run = (state_q != ST_IDLE);

    clg_window #(.WIN_LEN(WIN_LEN), .MIN_TOG(MIN_TOG)) u_win (
        .clk      (ref_clk),
        .arst     (por_rst),
        .run      (run),
        .tick     (tick),
        .win_end  (win_end),
        .win_pass (win_pass)
    );

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        trip_now = 1'b0;
        if (!en_q || stop_s) begin
            state_d = ST_IDLE;                         // SUSPEND
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_RUN;             // ARM
                ST_RUN: begin
                    if (win_end && !win_pass) begin
                        state_d  = ST_TRIP;            // TRIP
                        trip_now = 1'b1;
                    end
                end
                ST_TRIP: begin
                    if (win_end) begin
                        if (win_pass) state_d = ST_HEAL;   // MEND
                        else          trip_now = 1'b1;     // HOLD
                    end
                end
                ST_HEAL: begin
                    if (win_end) begin
                        if (win_pass) begin
                            state_d = ST_RUN;          // CLEAR
                        end else begin
                            state_d  = ST_TRIP;        // RELAPSE
                            trip_now = 1'b1;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge ref_clk or posedge por_rst) begin
        if (por_rst) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge ref_clk or posedge por_rst) begin
        if (por_rst) begin
            rst_req   <= 1'b0;
            fail_flag <= 1'b0;
        end else begin
            rst_req <= (state_d == ST_TRIP) || (state_d == ST_HEAL);
            if (trip_now)         fail_flag <= 1'b1;
            else if (sw_flag_clr) fail_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/clk_loss_guard_chk.sv
module clk_loss_guard_chk
    import clg_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         rst_req,
    input logic         fail_flag,
    input logic         pfail_rst,
    input logic         sw_flag_clr,
    input logic         en_q,
    input logic         stop_s,
    input logic         win_end,
    input logic         win_pass,
    input logic         trip_now,
    input guard_state_t state_q
);
    a_r2_rise_sets_flag: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req) |-> fail_flag)
        else $error("R2: request rose without flag");

    a_r3_hold_between_windows: assert property (@(posedge clk) disable iff (rst)
        (rst_req && en_q && !stop_s && !win_end) |=> rst_req)
        else $error("R3: request dropped mid-window");

    a_r4_release_after_heal: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HEAL && win_end && win_pass && en_q && !stop_s) |=> !rst_req)
        else $error("R4: second pass did not release");

    a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> !rst_req)
        else $error("R6: request while disabled");

    a_r7_stop_quiet: assert property (@(posedge clk) disable iff (rst)
        stop_s |=> !rst_req)
        else $error("R7: request during stop mode");

    a_r8_pfail_drops: assert property (@(posedge clk) disable iff (rst)
        pfail_rst |=> !rst_req)
        else $error("R8: request survived power-fail");

    a_r9_sw_clear: assert property (@(posedge clk) disable iff (rst)
        (sw_flag_clr && !trip_now) |=> !fail_flag)
        else $error("R9: flag not cleared");

    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        trip_now |=> fail_flag)
        else $error("R10: failing verdict did not set flag");
endmodule

bind clk_loss_guard clk_loss_guard_chk u_chk (
    .clk         (ref_clk),
    .rst         (por_rst),
    .rst_req     (rst_req),
    .fail_flag   (fail_flag),
    .pfail_rst   (pfail_rst),
    .sw_flag_clr (sw_flag_clr),
    .en_q        (en_q),
    .stop_s      (stop_s),
    .win_end     (win_end),
    .win_pass    (win_pass),
    .trip_now    (trip_now),
    .state_q     (state_q)
);

// File: tb/sim_clk_loss_guard.sv
`timescale 1ns/1ps
module sim_clk_loss_guard;
    localparam int WIN = 256;

    logic ref_clk = 1'b0;
    logic main_clk = 1'b0;
    logic por_rst = 1'b1, pfail_rst = 1'b1;
    logic sw_en_we = 1'b0, sw_en_wd = 1'b0, sw_flag_clr = 1'b0, stop_req = 1'b0;
    logic rst_req, fail_flag;

    int main_mode = 2;   // 0 stopped, 1 slow, 2 fast
    int checks = 0, failures = 0, cyc_n = 0;
    bit cmp_on = 1'b0, done = 1'b0;
    string phase = "R1";

    // reference model state
    int m_st = 0, m_wc = 0;
    bit m_en = 1'b0, m_req = 1'b0, m_flag = 1'b0, m_s1 = 1'b0, m_s2 = 1'b0;

    clk_loss_guard u0 (
        .ref_clk(ref_clk), .main_clk(main_clk), .por_rst(por_rst),
        .pfail_rst(pfail_rst), .sw_en_we(sw_en_we), .sw_en_wd(sw_en_wd),
        .sw_flag_clr(sw_flag_clr), .stop_req(stop_req),
        .rst_req(rst_req), .fail_flag(fail_flag)
    );

    always #5 ref_clk = ~ref_clk;

    always begin
        if (main_mode == 0) begin
            main_clk = 1'b0;
            wait (main_mode != 0);
        end else begin
            #(main_mode == 2 ? 11 : 700);
            main_clk = ~main_clk;
        end
    end

    // Behavioural model, updated on each reference edge
    always @(posedge ref_clk) begin
        int  nxt;
        bit  pass, fail_v;
        if (pfail_rst) m_en = 1'b0;
        if (por_rst) begin
            m_st = 0; m_wc = 0; m_req = 0; m_flag = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            nxt = m_st; fail_v = 0;
            if (!m_en || m_s2) nxt = 0;
            else if (m_st == 0) nxt = 1;
            else if (m_wc == WIN - 1) begin
                pass = (main_mode == 2);
                fail_v = !pass;
                if (m_st == 1)      nxt = pass ? 1 : 2;
                else if (m_st == 2) nxt = pass ? 3 : 2;
                else                nxt = pass ? 1 : 2;
            end
            if (m_st == 0) m_wc = 0;
            else m_wc = (m_wc == WIN - 1) ? 0 : m_wc + 1;
            m_req = (nxt == 2 || nxt == 3);
            if (fail_v) m_flag = 1'b1;
            else if (sw_flag_clr) m_flag = 1'b0;
            if (sw_en_we && !pfail_rst) m_en = sw_en_wd;
            m_st = nxt;
            m_s2 = m_s1;
            m_s1 = stop_req;
        end
        #3;
        if (cmp_on && !done) begin
            checks++;
            if (rst_req !== m_req || fail_flag !== m_flag) begin
                failures++;
                $display("FAIL %s cycle compare: req=%0b flag=%0b expected req=%0b flag=%0b",
                         phase, rst_req, fail_flag, m_req, m_flag);
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge ref_clk) begin
        cyc_n++;
        if (cyc_n > 150000 && !done) begin
            failures++;
            $display("FAIL watchdog expired (all requirements) act=%0d exp<=150000", cyc_n);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic at_window_start();
        @(negedge ref_clk);
        while (!(m_st != 0 && m_wc == 0)) @(negedge ref_clk);
    endtask

    task automatic at_window_last();
        @(negedge ref_clk);
        while (!(m_st != 0 && m_wc == WIN - 1)) @(negedge ref_clk);
    endtask

    task automatic wr_en(input bit v);
        @(negedge ref_clk);
        sw_en_we = 1'b1; sw_en_wd = v;
        @(negedge ref_clk);
        sw_en_we = 1'b0;
    endtask

    initial begin
        cyc(4);
        por_rst = 1'b0; pfail_rst = 1'b0;
        cmp_on = 1'b1;
        cyc(2);
        chk(rst_req == 0 && fail_flag == 0, "R1 reset state", {rst_req, fail_flag}, 0);

        // R1: disabled, slow clock
        main_mode = 1;
        cyc(800);
        chk(rst_req == 0, "R1 disabled no request", rst_req, 0);

        // R5: enabled with a fast clock
        phase = "R5";
        main_mode = 2;
        wr_en(1);
        cyc(WIN * 4);
        chk(rst_req == 0, "R5 fast clock no request", rst_req, 0);

        // R2: slow clock trips at window end
        phase = "R2";
        at_window_start();
        main_mode = 1;
        at_window_last();
        chk(rst_req == 0, "R2 before verdict", rst_req, 0);
        cyc(1);
        chk(rst_req == 1 && fail_flag == 1, "R2 trip and flag", {rst_req, fail_flag}, 3);

        // R3: held while slow
        phase = "R3";
        cyc(600);
        chk(rst_req == 1, "R3 held", rst_req, 1);

        // R4: one pass then fail, then two passes
        phase = "R4";
        at_window_start();
        main_mode = 2;
        at_window_start();
        chk(rst_req == 1, "R4 one pass keeps request", rst_req, 1);
        main_mode = 1;
        at_window_start();
        chk(rst_req == 1, "R4 relapse", rst_req, 1);
        main_mode = 2;
        at_window_start();
        chk(rst_req == 1, "R4 first of two passes", rst_req, 1);
        at_window_start();
        chk(rst_req == 0, "R4 released after two passes", rst_req, 0);

        // R9: software clears flag
        phase = "R9";
        @(negedge ref_clk); sw_flag_clr = 1'b1;
        @(negedge ref_clk); sw_flag_clr = 1'b0;
        chk(fail_flag == 0, "R9 software clear", fail_flag, 0);

        // R10: clear coincides with failing verdict
        phase = "R10";
        at_window_start();
        main_mode = 1;
        at_window_last();
        sw_flag_clr = 1'b1;
        @(negedge ref_clk); sw_flag_clr = 1'b0;
        chk(fail_flag == 1, "R10 set wins over clear", fail_flag, 1);
        chk(rst_req == 1, "R10 trip with clear", rst_req, 1);

        // R7: stop mode suppresses
        phase = "R7";
        @(negedge ref_clk);
        stop_req = 1'b1; main_mode = 0;
        cyc(2);
        chk(rst_req == 1, "R7 sync latency", rst_req, 1);
        cyc(1);
        chk(rst_req == 0, "R7 dropped by stop", rst_req, 0);
        cyc(700);
        chk(rst_req == 0 && fail_flag == 1, "R7 quiet in stop, flag kept", {rst_req, fail_flag}, 1);
        stop_req = 1'b0; main_mode = 2;
        cyc(600);
        chk(rst_req == 0, "R7 fast after stop", rst_req, 0);

        // R6: disable drops request
        phase = "R6";
        at_window_start();
        main_mode = 1;
        at_window_start();
        chk(rst_req == 1, "R6 tripped first", rst_req, 1);
        wr_en(0);
        chk(rst_req == 1, "R6 one edge after write", rst_req, 1);
        cyc(1);
        chk(rst_req == 0, "R6 dropped", rst_req, 0);

        // R8: power-fail clears enable, keeps flag
        phase = "R8";
        wr_en(1);
        at_window_start();
        at_window_start();
        chk(rst_req == 1, "R8 tripped first", rst_req, 1);
        @(negedge ref_clk); pfail_rst = 1'b1;
        @(negedge ref_clk); pfail_rst = 1'b0;
        chk(rst_req == 0 && fail_flag == 1, "R8 drop, flag kept", {rst_req, fail_flag}, 1);
        cyc(600);
        chk(rst_req == 0, "R8 stays disabled", rst_req, 0);

        // R9: power-on reset clears flag, keeps enable
        phase = "R9";
        wr_en(1);
        cyc(300);
        chk(rst_req == 1 && fail_flag == 1, "R9 tripped before por", {rst_req, fail_flag}, 3);
        @(negedge ref_clk); por_rst = 1'b1;
        @(negedge ref_clk); por_rst = 1'b0;
        chk(rst_req == 0 && fail_flag == 0, "R9 por clears", {rst_req, fail_flag}, 0);
        cyc(270);
        chk(rst_req == 1, "R9 enable survives por", rst_req, 1);

        // R11: exact arming-to-verdict timing
        phase = "R11";
        wr_en(0);
        cyc(4);
        wr_en(1);
        cyc(WIN);
        chk(rst_req == 0, "R11 no verdict yet", rst_req, 0);
        cyc(1);
        chk(rst_req == 1, "R11 verdict at WIN after arm", rst_req, 1);

        cyc(3);
        finish_run();
    end
endmodule